// File: doc/BRIEF.md
# SPI Host Power-Up Command Sequencer

This block is a host-side serial master. It brings a CRC-protected converter out of reset. A single start pulse makes it send an ordered power-up script over a four-wire link. The link uses clock mode 1: the clock rests low, the host changes its data line on each rising edge, and the device samples on each falling edge. The script is a two-key software reset, then a calibration refresh, then a write that clears the sticky reset-occurred flag in the diagnostic register.

Each 32-bit word is built in hardware from a command table. The fields are a slip bit, two device-select bits, a five-bit register index, sixteen data bits and a CRC-8 trailer. The CRC is computed over the upper 24 bits with polynomial x^8 + x^2 + x + 1, starting from zero and processing the MSB first. When the optional readback is enabled, two more words follow. The first selects the diagnostic register for readback and the second is a no-operation word. During the no-operation word the reply on the device's data output is captured. The captured word is then checked for a valid header and a valid CRC.

Software sets the serial clock rate through a half-period input. It watches the busy and done outputs, and it reads the captured word together with its error flag.

Top module: `spi_init_seq`

## Requirements
- R1: While reset is asserted and after it is released, sclk is 0, sync_n is 1, and busy, done and rb_err are 0.
- R2: With readback_en low, one start sends exactly four words in this order: 0x8815FAA4, 0x88AF5131, 0x88FCBA9D, 0x942000AC. Each word is laid out as bit 31 = slip bit (the inverse of bit 30), bits 30:29 = device select (00), bits 28:24 = register index, bits 23:8 = data, and bits 7:0 = CRC-8 (polynomial 0x07, initial value 0, MSB first over bits 31:8).
- R3: With readback_en high at start, the same four words are followed by 0x93001478 and then 0x8000000B, for six words in total.
- R4: Each word is framed by sync_n low for exactly 32 rising and 32 falling sclk edges, and sclk is low whenever sync_n is high or changes.
- R5: While sync_n stays low, sdi changes only in the cycle in which sclk rises. The words are sent MSB first.
- R6: Each sclk level lasts exactly max(half_div, 1) system clock cycles while sync_n is low.
- R7: sync_n stays high for at least GAP_CYC system clocks between two words.
- R8: When a readback run completes, rb_word holds the 32 bits sampled from sdo on the falling sclk edges of the last word, MSB first. rb_word changes only in the cycle in which done rises.
- R9: After a readback run, rb_err is 0 only if rb_word bits 31:30 are 10 and rb_word bits 7:0 equal the CRC-8 of rb_word bits 31:8. After a run without readback, rb_err is 0.
- R10: busy rises only in the cycle after start is sampled, and it stays high until the last word's gap ends. At that point done rises, and done stays high until the next start. A start pulse seen while busy is ignored, so the run still sends the same number of words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch the power-up script (ignored while busy) |
| readback_en | input | 1 | Append the diagnostic readback pair to the script |
| half_div | input | DIV_W | sclk half period in system clocks (0 acts as 1) |
| sdo | input | 1 | Serial data from the device |
| sclk | output | 1 | Serial clock, idles low |
| sync_n | output | 1 | Active-low frame select |
| sdi | output | 1 | Serial data to the device |
| busy | output | 1 | Script in progress |
| done | output | 1 | Script finished, held until next start |
| rb_word | output | 32 | Word captured during the no-operation frame |
| rb_err | output | 1 | Captured word has a bad header or CRC |

## Verification
A wrong word index or a corrupted command table shows up as the wrong 32-bit word at the bench's device model, within the same frame. A CRC fault shows up as a changed trailer byte in that word. A wrong bit or divider count is visible within one frame, as an sclk edge count other than 32 or as a level held for the wrong number of clocks. An error in the run-length logic shows up at done as four words where six were expected, or six where four were expected. A fault in the capture or check logic shows up at done in rb_word or rb_err, and the bench feeds the model a good reply, a reply with a bad header and a reply with a bad CRC to expose it.

// File: rtl/spi_init_pkg.sv
package spi_init_pkg;
  localparam int FRAME_W = 32;
  localparam int PAY_W   = 24;
  localparam int CRC_W   = 8;

  typedef struct packed {
    logic [4:0]  reg_a;
    logic [15:0] data;
  } cmd_t;

  typedef enum logic [1:0] {E_IDLE, E_RUN, E_GAP} eng_st_t;
  typedef enum logic [1:0] {T_IDLE, T_ISSUE, T_WAIT} seq_st_t;

  localparam logic [4:0]  REG_KEY   = 5'h08;
  localparam logic [4:0]  REG_DIAG  = 5'h14;
  localparam logic [4:0]  REG_RBSEL = 5'h13;
  localparam logic [4:0]  REG_NOP   = 5'h00;
  localparam logic [15:0] KEY_RST_A = 16'h15FA;
  localparam logic [15:0] KEY_RST_B = 16'hAF51;
  localparam logic [15:0] KEY_CAL   = 16'hFCBA;
  localparam logic [15:0] CLR_RSTOC = 16'h2000;

  localparam logic [2:0] LAST_BASE = 3'd3;
  localparam logic [2:0] LAST_FULL = 3'd5;
endpackage

// File: rtl/spi_crc8.sv
module spi_crc8
  import spi_init_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY = 8'h07
) (
  input  logic [PAY_W-1:0] payload,
  output logic [CRC_W-1:0] crc
);
  always_comb begin
    logic fb;
    crc = '0;
    for (int i = PAY_W - 1; i >= 0; i--) begin
      fb  = crc[CRC_W-1] ^ payload[i];
      crc = {crc[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
  end
endmodule

// File: rtl/spi_init_rom.sv
module spi_init_rom
  import spi_init_pkg::*;
(
  input  logic [2:0] idx,
  output cmd_t       cmd
);
  always_comb begin
    unique case (idx)
      3'd0:    cmd = '{reg_a: REG_KEY,   data: KEY_RST_A};
      3'd1:    cmd = '{reg_a: REG_KEY,   data: KEY_RST_B};
      3'd2:    cmd = '{reg_a: REG_KEY,   data: KEY_CAL};
      3'd3:    cmd = '{reg_a: REG_DIAG,  data: CLR_RSTOC};
      3'd4:    cmd = '{reg_a: REG_RBSEL, data: {11'd0, REG_DIAG}};
      default: cmd = '{reg_a: REG_NOP,   data: 16'h0000};
    endcase
  end
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import spi_init_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int GAP_CYC = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go,
  input  logic [FRAME_W-1:0] frame,
  input  logic [DIV_W-1:0]   half_div,
  input  logic               sdo,
  output logic               sclk,
  output logic               sync_n,
  output logic               sdi,
  output logic [FRAME_W-1:0] rx,
  output logic               fin
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam int GAP_W = $clog2(GAP_CYC + 1);
  localparam logic [CNT_W-1:0] EDGES    = CNT_W'(FRAME_W);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_CYC - 1);

  eng_st_t            st;
  logic [FRAME_W-1:0] sh;
  logic [DIV_W-1:0]   cnt;
  logic [DIV_W-1:0]   hd_m1;
  logic [CNT_W-1:0]   nfall;
  logic [GAP_W-1:0]   gcnt;

  assign hd_m1 = (half_div == '0) ? '0 : half_div - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= E_IDLE;
      sclk   <= 1'b0;
      sync_n <= 1'b1;
      sdi    <= 1'b0;
      sh     <= '0;
      rx     <= '0;
      cnt    <= '0;
      nfall  <= '0;
      gcnt   <= '0;
      fin    <= 1'b0;
    end else begin
      fin <= 1'b0;
      unique case (st)
        E_IDLE: if (go) begin
          sh     <= frame;
          sync_n <= 1'b0;
          cnt    <= '0;
          nfall  <= '0;
          st     <= E_RUN;
        end
        E_RUN: begin
          if (cnt == hd_m1) begin
            cnt <= '0;
            if (nfall == EDGES) begin
              sync_n <= 1'b1;
              sdi    <= 1'b0;
              gcnt   <= '0;
              st     <= E_GAP;
            end else if (!sclk) begin
              sclk <= 1'b1;
              sdi  <= sh[FRAME_W-1];
              sh   <= {sh[FRAME_W-2:0], 1'b0};
            end else begin
              sclk  <= 1'b0;
              rx    <= {rx[FRAME_W-2:0], sdo};
              nfall <= nfall + 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (gcnt == GAP_LAST) begin
            fin <= 1'b1;
            st  <= E_IDLE;
          end else begin
            gcnt <= gcnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/spi_init_seq.sv
module spi_init_seq
  import spi_init_pkg::*;
#(
  parameter logic [1:0] DEV_ADDR = 2'b00,
  parameter int         DIV_W    = 8,
  parameter int         GAP_CYC  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             readback_en,
  input  logic [DIV_W-1:0] half_div,
  input  logic             sdo,
  output logic             sclk,
  output logic             sync_n,
  output logic             sdi,
  output logic             busy,
  output logic             done,
  output logic [31:0]      rb_word,
  output logic             rb_err
);
  seq_st_t            st;
  logic [2:0]         idx;
  logic               rb_lat;
  logic               go;
  logic               fin;
  cmd_t               cmd;
  logic [PAY_W-1:0]   tx_pay;
  logic [CRC_W-1:0]   tx_crc;
  logic [CRC_W-1:0]   rx_crc;
  logic [FRAME_W-1:0] rx;
  logic [2:0]         last_idx;
  logic               rx_bad;

  spi_init_rom i_rom (.idx(idx), .cmd(cmd));

  assign tx_pay = {~DEV_ADDR[1], DEV_ADDR, cmd.reg_a, cmd.data};

  spi_crc8 i_tx_crc (.payload(tx_pay), .crc(tx_crc));
  spi_crc8 i_rx_crc (.payload(rx[FRAME_W-1:CRC_W]), .crc(rx_crc));

  spi_frame_engine #(.DIV_W(DIV_W), .GAP_CYC(GAP_CYC)) i_eng (
    .clk(clk), .rst(rst), .go(go), .frame({tx_pay, tx_crc}),
    .half_div(half_div), .sdo(sdo), .sclk(sclk), .sync_n(sync_n),
    .sdi(sdi), .rx(rx), .fin(fin)
  );

  assign last_idx = rb_lat ? LAST_FULL : LAST_BASE;
  assign rx_bad   = (rx[FRAME_W-1:FRAME_W-2] != 2'b10) || (rx_crc != rx[CRC_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= T_IDLE;
      idx     <= '0;
      rb_lat  <= 1'b0;
      go      <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      rb_word <= '0;
      rb_err  <= 1'b0;
    end else begin
      unique case (st)
        T_IDLE: if (start) begin
          idx    <= '0;
          rb_lat <= readback_en;
          busy   <= 1'b1;
          done   <= 1'b0;
          rb_err <= 1'b0;
          st     <= T_ISSUE;
        end
        T_ISSUE: begin
          go <= 1'b1;
          st <= T_WAIT;
        end
        default: begin
          go <= 1'b0;
          if (fin) begin
            if (idx == last_idx) begin
              busy <= 1'b0;
              done <= 1'b1;
              st   <= T_IDLE;
              if (rb_lat) begin
                rb_word <= rx;
                rb_err  <= rx_bad;
              end
            end else begin
              idx <= idx + 1'b1;
              st  <= T_ISSUE;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/spi_init_seq_chk.sv
module spi_init_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        sclk,
  input logic        sync_n,
  input logic        sdi,
  input logic [31:0] rb_word
);
  assert_sclk_idle_R4: assert property (@(posedge clk) disable iff (rst)
    sync_n |-> !sclk);

  assert_sync_edge_low_R4: assert property (@(posedge clk) disable iff (rst)
    (sync_n != $past(sync_n)) |-> (!sclk && !$past(sclk)));

  assert_sdi_on_rise_R5: assert property (@(posedge clk) disable iff (rst)
    (!sync_n && !$past(sync_n) && (sdi != $past(sdi))) |-> (sclk && !$past(sclk)));

  assert_busy_from_start_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_word_on_done_R8: assert property (@(posedge clk) disable iff (rst)
    (rb_word != $past(rb_word)) |-> $rose(done));
endmodule

bind spi_init_seq spi_init_seq_chk i_chk (.*);

// File: tb/test_spi_init_seq.sv
module test_spi_init_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W      = 8;
  localparam int GAP_CYC    = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic             readback_en = 1'b0;
  logic [DIV_W-1:0] half_div = 8'd1;
  logic             sdo = 1'b0;
  logic             sclk, sync_n, sdi, busy, done, rb_err;
  logic [31:0]      rb_word;

  spi_init_seq #(.DIV_W(DIV_W), .GAP_CYC(GAP_CYC)) i_spi_init_seq (
    .clk(clk), .rst(rst), .start(start), .readback_en(readback_en),
    .half_div(half_div), .sdo(sdo), .sclk(sclk), .sync_n(sync_n), .sdi(sdi),
    .busy(busy), .done(done), .rb_word(rb_word), .rb_err(rb_err)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] crc8(input logic [23:0] p);
    logic [8:0] r;
    r = '0;
    for (int i = 23; i >= 0; i--) begin
      r = {r[7:0], 1'b0};
      if (r[8] ^ p[i]) r[7:0] = r[7:0] ^ 8'h07;
      r[8] = 1'b0;
    end
    return r[7:0];
  endfunction

  // device model
  bit          armed = 0;
  logic [31:0] resp = 32'h0;
  logic [31:0] tx_sh, rx_sh;
  int          nrise, nfall_m;
  logic [31:0] got [8];
  int          nfr = 0;
  int          bad_bits = 0;

  always @(negedge sync_n) if (armed) begin
    tx_sh = resp; nrise = 0; nfall_m = 0;
  end
  always @(posedge sclk) if (armed && !sync_n) begin
    sdo = tx_sh[31]; tx_sh = {tx_sh[30:0], 1'b0}; nrise++;
  end
  always @(negedge sclk) if (armed && !sync_n) begin
    rx_sh = {rx_sh[30:0], sdi}; nfall_m++;
  end
  always @(posedge sync_n) if (armed) begin
    if (nfr < 8) got[nfr] = rx_sh;
    if (nrise != 32 || nfall_m != 32) bad_bits++;
    nfr++;
  end

  // timing monitors
  int   cyc = 0, last_t = 0, exp_hd = 1, per_err = 0;
  int   rise_t = 0, min_gap = 1000000;
  bit   seen = 0, rv = 0;
  logic prev_sclk = 1'b0, prev_sync = 1'b1;

  always @(negedge clk) begin
    cyc++;
    if (armed) begin
      if (sclk !== prev_sclk && !sync_n) begin
        if (seen && (cyc - last_t) != exp_hd) per_err++;
        last_t = cyc; seen = 1;
      end
      if (sync_n) seen = 0;
      if (sync_n && !prev_sync) begin rise_t = cyc; rv = 1; end
      if (!sync_n && prev_sync && rv && (cyc - rise_t) < min_gap) min_gap = cyc - rise_t;
    end
    prev_sclk = sclk;
    prev_sync = sync_n;
  end

  logic [31:0] exp_fr [6];

  task automatic run(input int hd, input bit rb, input logic [31:0] r, input bit exp_err, input bit dbl_start);
    int n_exp;
    n_exp = rb ? 6 : 4;
    resp = r; nfr = 0; bad_bits = 0; per_err = 0; min_gap = 1000000; rv = 0;
    exp_hd = (hd == 0) ? 1 : hd;
    @(negedge clk);
    half_div = DIV_W'(hd); readback_en = rb; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1 && done === 1'b0, "R10 busy after start", {30'd0, busy, done}, 32'h2);
    if (dbl_start) begin
      repeat (40) @(negedge clk);
      readback_en = ~rb; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (done !== 1'b1) @(negedge clk);
    chk(busy === 1'b0, "R10 busy low at done", {31'd0, busy}, 32'h0);
    chk(nfr == n_exp, rb ? "R3 word count" : "R2 word count", nfr, n_exp);
    for (int i = 0; i < n_exp && i < nfr; i++)
      chk(got[i] === exp_fr[i], rb ? "R3 word value" : "R2 word value", got[i], exp_fr[i]);
    chk(bad_bits == 0, "R4 32 edges per frame", bad_bits, 0);
    chk(per_err == 0, "R6 sclk half period", per_err, 0);
    chk(min_gap >= GAP_CYC, "R7 sync high gap", min_gap, GAP_CYC);
    if (rb) chk(rb_word === r, "R8 captured word", rb_word, r);
    chk(rb_err === exp_err, "R9 readback check", {31'd0, rb_err}, {31'd0, exp_err});
    repeat (3) @(negedge clk);
    chk(done === 1'b1 && sync_n === 1'b1 && sclk === 1'b0, "R10 done held, R4 idle", {29'd0, done, sync_n, sclk}, 32'h6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] good, badh, badc;
    exp_fr[0] = 32'h8815FAA4; exp_fr[1] = 32'h88AF5131;
    exp_fr[2] = 32'h88FCBA9D; exp_fr[3] = 32'h942000AC;
    exp_fr[4] = 32'h93001478; exp_fr[5] = 32'h8000000B;
    // R2: the frames are slip|addr|reg|data|crc, cross-checked arithmetically
    chk(exp_fr[0] === {1'b1, 2'b00, 5'h08, 16'h15FA, crc8({1'b1, 2'b00, 5'h08, 16'h15FA})},
        "R2 frame layout", exp_fr[0], {1'b1, 2'b00, 5'h08, 16'h15FA, crc8({1'b1, 2'b00, 5'h08, 16'h15FA})});
    good = {24'h94A000, crc8(24'h94A000)};
    badh = {24'h54A000, crc8(24'h54A000)};
    badc = good ^ 32'h1;
    repeat (3) @(negedge clk);
    chk(sclk === 1'b0 && sync_n === 1'b1 && busy === 1'b0 && done === 1'b0 && rb_err === 1'b0,
        "R1 in reset", {27'd0, sclk, sync_n, busy, done, rb_err}, 32'h8);
    rst = 1'b0;
    @(negedge clk);
    chk(sclk === 1'b0 && sync_n === 1'b1 && busy === 1'b0 && done === 1'b0 && rb_err === 1'b0,
        "R1 after reset", {27'd0, sclk, sync_n, busy, done, rb_err}, 32'h8);
    armed = 1;
    foreach (exp_fr[i]) begin end
    for (int h = 0; h < 6; h++) begin
      int hv;
      hv = (h == 5) ? 5 : h;
      for (int b = 0; b < 2; b++) run(hv, b[0], good, 1'b0, 1'b0);
    end
    run(2, 1'b1, badc, 1'b1, 1'b0);   // R9 bad CRC
    run(3, 1'b1, badh, 1'b1, 1'b0);   // R9 bad header
    run(2, 1'b0, good, 1'b0, 1'b1);   // R10 start while busy ignored
    run(1, 1'b1, good, 1'b0, 1'b1);   // R10 start while busy ignored
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule